// File: doc/BRIEF.md
# Two-Wire Scan Bit Serializer

This block sits on the probe side of a two-wire debug link. It turns each four-wire scan bit into the two-wire form. A bit request carries a TDI value, a TMS value and a capture flag, and it arrives on a valid/ready stream. The block plays that bit out as three TCK periods on one clock pin and one shared bidirectional data pin (TMSC):

- In the first period the probe drives the inverse of TDI.
- In the second period the probe drives TMS.
- In the third period the probe lets go of the pin so the target can answer with its TDO bit.

When the capture flag is set, the sampled TDO bit goes back upstream on a second valid/ready stream.

The layer above decides what goes into each request. That layer orders the bits least-significant first and raises TMS only on the last bit of a scan.

The TCK rate comes from a plain control input. That input gives the number of system clocks in each TCK half-period.

Back-pressure works as follows:

- A request is taken on any clock where `in_valid` and `in_ready` are both high.
- `in_ready` is high only when the serializer is idle and no captured result is waiting.
- A captured result stays on `out_tdo` with `out_valid` high until `out_ready` is seen high. No new bit starts before then.

Top module: `oscan1_serializer`

## Requirements
- R1: Every accepted request produces exactly three rising edges on `tck` before the block is ready again.
- R2: During the first period `tmsc_oe` is 1 and `tmsc_o` equals the inverse of the requested TDI bit.
- R3: During the second period `tmsc_oe` is 1 and `tmsc_o` equals the requested TMS bit.
- R4: During the third period `tmsc_oe` is 0. The value on `tmsc_i` at that period's rising `tck` edge is the bit returned on `out_tdo`.
- R5: `tmsc_o` and `tmsc_oe` change only while `tck` is low, so they move on falling edges or before the first rise. They hold steady through each rising edge and each high phase.
- R6: A request with the capture flag at 0 returns no `out_valid` pulse, and a request with it at 1 returns exactly one.
- R7: When idle and with no result pending, `tck` is 0, `tmsc_oe` is 1, `tmsc_o` is 0 and `in_ready` is 1.
- R8: Each high and low phase of `tck` lasts `half_div` system clocks, and a `half_div` of 0 behaves as 1.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_tdo` hold their values. During that time `in_ready` is 0 and no `tck` edge occurs.
- R10: After reset `tck` is 0, `tmsc_oe` is 1, `tmsc_o` is 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | System clocks per TCK half-period (0 treated as 1) |
| in_valid | input | 1 | Bit request valid |
| in_ready | output | 1 | Bit request accepted when high with in_valid |
| in_tdi | input | 1 | Requested TDI value |
| in_tms | input | 1 | Requested TMS value |
| in_cap | input | 1 | Return the sampled TDO bit upstream |
| out_valid | output | 1 | Captured TDO bit valid |
| out_ready | input | 1 | Upstream takes the captured bit |
| out_tdo | output | 1 | Captured TDO bit |
| tck | output | 1 | Link clock pin |
| tmsc_o | output | 1 | Data pin output value |
| tmsc_oe | output | 1 | Data pin output enable |
| tmsc_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with the default `DIV_W` of 8 and changes the divider at run time through `half_div`. It uses the values 1, 3 and 0, so it covers both the shortest link clock and a multi-clock half-period, and it confirms that 0 falls back to 1. The target model drives the inverse of the expected TDO bit whenever the probe holds the pin. A sample taken outside the turnaround period therefore shows up as a wrong result. Holding `out_ready` low makes the pending-result stall observable at the pins.

// File: rtl/oscan1_pkg.sv
package oscan1_pkg;
  typedef enum logic [1:0] {
    PH_TDI = 2'd0,
    PH_TMS = 2'd1,
    PH_TDO = 2'd2
  } phase_e;

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_TDI:  return PH_TMS;
      PH_TMS:  return PH_TDO;
      default: return PH_TDI;
    endcase
  endfunction
endpackage

// File: rtl/oscan1_halfdiv.sv
module oscan1_halfdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (half == '0) ? DIV_W'(1) : half;
  assign tick = en && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/oscan1_seq.sv
module oscan1_seq
  import oscan1_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_tdi,
  input  logic req_tms,
  input  logic req_cap,
  input  logic tick,
  input  logic tmsc_i,
  output logic busy,
  output logic tck,
  output logic tmsc_o,
  output logic tmsc_oe,
  output logic cap_done,
  output logic cap_bit
);
  phase_e phase;
  logic   tck_q, tdi_q, tms_q, cap_q, samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= PH_TDI;
      tck_q  <= 1'b0;
      tdi_q  <= 1'b0;
      tms_q  <= 1'b0;
      cap_q  <= 1'b0;
      samp_q <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= PH_TDI;
      tck_q <= 1'b0;
      tdi_q <= req_tdi;
      tms_q <= req_tms;
      cap_q <= req_cap;
    end else if (busy && tick) begin
      if (!tck_q) begin
        tck_q <= 1'b1;
        if (phase == PH_TDO) samp_q <= tmsc_i;
      end else begin
        tck_q <= 1'b0;
        if (phase == PH_TDO) busy  <= 1'b0;
        else                 phase <= next_phase(phase);
      end
    end
  end

  assign tck      = tck_q;
  assign cap_done = busy && tick && tck_q && (phase == PH_TDO) && cap_q;
  assign cap_bit  = samp_q;

  always_comb begin
    tmsc_o  = 1'b0;
    tmsc_oe = 1'b1;
    if (busy) begin
      case (phase)
        PH_TDI:  tmsc_o  = ~tdi_q;
        PH_TMS:  tmsc_o  = tms_q;
        default: tmsc_oe = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/oscan1_result.sv
module oscan1_result (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_bit,
  input  logic out_ready,
  output logic out_valid,
  output logic out_tdo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tdo   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_tdo   <= load_bit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/oscan1_serializer.sv
module oscan1_serializer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_tdi,
  input  logic             in_tms,
  input  logic             in_cap,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_tdo,
  output logic             tck,
  output logic             tmsc_o,
  output logic             tmsc_oe,
  input  logic             tmsc_i
);
  logic busy, tick, start, cap_done, cap_bit;

  assign in_ready = !busy && !out_valid;
  assign start    = in_valid && in_ready;

  oscan1_halfdiv #(.DIV_W(DIV_W)) u_div (
    .clk (clk),
    .rst_n (rst_n),
    .en (busy),
    .half (half_div),
    .tick (tick)
  );

  oscan1_seq u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .start (start),
    .req_tdi (in_tdi),
    .req_tms (in_tms),
    .req_cap (in_cap),
    .tick (tick),
    .tmsc_i (tmsc_i),
    .busy (busy),
    .tck (tck),
    .tmsc_o (tmsc_o),
    .tmsc_oe (tmsc_oe),
    .cap_done (cap_done),
    .cap_bit (cap_bit)
  );

  oscan1_result u_res (
    .clk (clk),
    .rst_n (rst_n),
    .load (cap_done),
    .load_bit (cap_bit),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_tdo (out_tdo)
  );
endmodule

// File: rtl/oscan1_serializer_chk.sv
module oscan1_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_tdo,
  input logic tck,
  input logic tmsc_o,
  input logic tmsc_oe
);
  AST_PIN_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> $stable(tmsc_o) && $stable(tmsc_oe)); // R5
  AST_OE_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmsc_oe) |-> !tck); // R5
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tck && tmsc_oe && !tmsc_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tdo)); // R9
  AST_STALL_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> !$rose(tck)); // R9
endmodule

bind oscan1_serializer oscan1_serializer_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .in_ready (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tdo (out_tdo),
  .tck (tck),
  .tmsc_o (tmsc_o),
  .tmsc_oe (tmsc_oe)
);

// File: tb/tb_oscan1_serializer.sv
module tb_oscan1_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic       in_valid = 1'b0, in_tdi = 1'b0, in_tms = 1'b0, in_cap = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_tdo, tck, tmsc_o, tmsc_oe, tmsc_i;
  logic       tgt_bit = 1'b0;
  int         errs = 0, checks = 0;

  always #10 clk = ~clk;

  // target model: drives the inverse of its answer while the probe holds the pin
  assign tmsc_i = tmsc_oe ? ~tgt_bit : tgt_bit;

  oscan1_serializer dut (
    .clk (clk), .rst_n (rst_n), .half_div (half_div),
    .in_valid (in_valid), .in_ready (in_ready), .in_tdi (in_tdi),
    .in_tms (in_tms), .in_cap (in_cap), .out_valid (out_valid),
    .out_ready (out_ready), .out_tdo (out_tdo), .tck (tck),
    .tmsc_o (tmsc_o), .tmsc_oe (tmsc_oe), .tmsc_i (tmsc_i)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(tck == 1'b0 && tmsc_oe == 1'b1 && tmsc_o == 1'b0, "R10 pins", {tck, tmsc_oe, tmsc_o}, 3'b010);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10 handshake", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic run_bit(input logic tdi, input logic tms, input logic cap,
                         input logic tgt, input int setting);
    int   h;
    int   rises = 0, hlen = 0, llen = 0, len_bad = 0, stab_bad = 0, outs = 0;
    logic got = 1'b0, ptck = 1'b0, po = 1'b0, poe = 1'b1;
    logic d[4];
    logic e[4];
    h = (setting == 0) ? 1 : setting;
    half_div = 8'(setting);
    tgt_bit = tgt;
    in_tdi = tdi; in_tms = tms; in_cap = cap;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ptck = 1'b0; po = tmsc_o; poe = tmsc_oe;
    for (int k = 0; k < 6 * h + 2; k++) begin
      if (tck && !ptck) begin
        if (rises < 4) begin d[rises] = tmsc_o; e[rises] = tmsc_oe; end
        if (rises > 0 && llen != h) len_bad++;
        if (tmsc_o != po || tmsc_oe != poe) stab_bad++;
        rises++; hlen = 1;
      end else if (tck) begin
        hlen++;
        if (tmsc_o != po || tmsc_oe != poe) stab_bad++;
      end else if (ptck) begin
        if (hlen != h) len_bad++;
        llen = 1;
      end else llen++;
      if (out_valid) begin outs++; got = out_tdo; end
      ptck = tck; po = tmsc_o; poe = tmsc_oe;
      @(negedge clk);
    end
    chk(rises == 3, "R1 rising edges", rises, 3);
    chk(d[0] == ~tdi && e[0] == 1'b1, "R2 first period", {e[0], d[0]}, {1'b1, ~tdi});
    chk(d[1] == tms && e[1] == 1'b1, "R3 second period", {e[1], d[1]}, {1'b1, tms});
    chk(e[2] == 1'b0, "R4 released", e[2], 0);
    if (cap) chk(got == tgt, "R4 captured bit", got, tgt);
    chk(stab_bad == 0, "R5 steady pin", stab_bad, 0);
    chk(outs == (cap ? 1 : 0), "R6 result count", outs, cap ? 1 : 0);
    chk(len_bad == 0, "R8 phase length", len_bad, 0);
    chk(in_ready && !tck && tmsc_oe && !tmsc_o, "R7 idle",
        {in_ready, tck, tmsc_oe, tmsc_o}, 4'b1010);
  endtask

  task automatic test_stall();
    int rises = 0;
    logic ptck = 1'b0;
    out_ready = 1'b0;
    half_div = 8'd1;
    tgt_bit = 1'b1;
    in_tdi = 1'b0; in_tms = 1'b0; in_cap = 1'b1;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_tdi = 1'b1;
    repeat (8) @(negedge clk);
    chk(out_valid && out_tdo == 1'b1, "R9 result held", {out_valid, out_tdo}, 2'b11);
    chk(!in_ready, "R9 ready low", in_ready, 0);
    for (int k = 0; k < 12; k++) begin
      if (tck && !ptck) rises++;
      ptck = tck;
      @(negedge clk);
    end
    chk(rises == 0, "R9 no clock while pending", rises, 0);
    chk(out_valid && out_tdo == 1'b1, "R9 still held", {out_valid, out_tdo}, 2'b11);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9 released", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_bit(1'b0, 1'b0, 1'b1, 1'b1, 1);
    run_bit(1'b1, 1'b0, 1'b1, 1'b0, 1);
    run_bit(1'b1, 1'b1, 1'b1, 1'b1, 3);
    run_bit(1'b0, 1'b1, 1'b0, 1'b1, 3);
    run_bit(1'b1, 1'b0, 1'b0, 1'b0, 0);
    run_bit(1'b0, 1'b1, 1'b1, 1'b0, 0);
    test_stall();
    run_bit(1'b1, 1'b1, 1'b1, 1'b0, 2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule